// File: doc/BRIEF.md
# Peripheral FIFO DMA Request Generator

This block sits beside a 16-entry peripheral data FIFO and decides which flow-control request to raise toward a DMA controller. There are four requests: single, burst, last-single and last-burst. The burst size is 8 words. The block works for both receive (peripheral to memory) and transmit (memory to peripheral).

In receive, the choice depends on the FIFO fill level and on the line-side data counter. That counter is an input and gives the words the line side still has to deliver. In transmit, the block keeps its own count of words still to be written into the FIFO. A start strobe loads that count from a programmed length, and each word pushed into the FIFO lowers it by one. The choice then depends on that count and on the free space in the FIFO.

A burst is never requested when fewer than 8 words remain, so the DMA controller cannot run past the end of a short transfer. A small transfer is served with single requests and ends with a last-single request. The outputs are registered. A clear input from the DMA controller drops every request for one cycle, which gives the counts time to update before the next request is evaluated.

Top module: `dma_req_gen`

## Requirements
- R1: Receive (dir_tx=0) single request: req_single rises when line_cnt is zero and fifo_level is between 2 and 7 inclusive.
- R2: Receive burst request: req_burst rises when fifo_level is exactly 8 and line_cnt is nonzero, or when fifo_level is above 8.
- R3: Receive last-single request: req_last_single rises when line_cnt is zero and fifo_level is exactly 1.
- R4: Receive last-burst request: req_last_burst rises when line_cnt is zero and fifo_level is exactly 8.
- R5: Receive wait: when line_cnt is nonzero and fifo_level is below 8, or when the FIFO is empty, no request is raised.
- R6: Transmit (dir_tx=1) request type follows the remaining count: above 8 gives burst, exactly 8 gives last-burst, 2 to 7 gives single, exactly 1 gives last-single.
- R7: Transmit space gating: a burst or last-burst needs at least 8 free FIFO entries (16 minus fifo_level), and a single or last-single needs at least 1. Otherwise no request is raised.
- R8: The remaining count loads xfer_len on start. It drops by one for each cycle with push high, and it stays at zero once there. While it is zero, transmit raises no request.
- R9: Requests are registered. Each reflects the inputs and count of the previous cycle, and at most one request is high in any cycle.
- R10: When dma_clr is high at a clock edge, all four requests are low after that edge. Evaluation resumes on the next edge.
- R11: A clock edge with rst_n low clears the remaining count and all request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| fifo_level | input | 5 | Words currently held in the FIFO (0 to 16) |
| line_cnt | input | 16 | Receive: words the line side still has to deliver |
| xfer_len | input | 16 | Transmit transfer length, loaded on start |
| start | input | 1 | Load strobe for the transmit remaining count |
| push | input | 1 | One word written into the FIFO (decrements the count) |
| dma_clr | input | 1 | DMA request clear; drops all requests for one cycle |
| req_single | output | 1 | Single-word request |
| req_burst | output | 1 | Burst request (8 words) |
| req_last_single | output | 1 | Final single-word request |
| req_last_burst | output | 1 | Final burst request (8 words) |

## Verification
The assertions assume that fifo_level never exceeds 16. They also assume that dir_tx is held steady while a transfer is in progress, so that each registered request can be traced to the previous cycle's level and count. The stimulus keeps to this: every vector applies a level between 0 and 16, and the direction changes only between vectors, with the outputs checked one edge after the inputs settle. Transmit vectors load the count with a start pulse and allow one further edge before checking. This matches the two register stages between xfer_len and a request output.

// File: rtl/dma_req_pkg.sv
// Shared parameters and the request-kind encoding for the DMA request generator.
package dma_req_pkg;
    // Which of the four requests (or none) the decoder selects this cycle.
    typedef enum logic [2:0] {
        REQ_NONE    = 3'd0,
        REQ_SINGLE  = 3'd1,
        REQ_BURST   = 3'd2,
        REQ_LSINGLE = 3'd3,
        REQ_LBURST  = 3'd4
    } req_kind_e;
endpackage

// File: rtl/tx_remain_cnt.sv
// Transmit remaining-word counter.
// Loads the programmed length on start. Decrements once per pushed word and
// saturates at zero. Assumes start and push are single-cycle qualified strobes;
// start wins if both are high.
module tx_remain_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             push,
    input  logic [CNT_W-1:0] xfer_len,
    output logic [CNT_W-1:0] remain
);
    // Hold, load or decrement the count of words still to enter the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= xfer_len;
        end else if (push && (remain != '0)) begin
            remain <= remain - CNT_W'(1);
        end
    end
endmodule

// File: rtl/req_decode.sv
// Combinational request classifier.
// Picks one request kind from the direction, FIFO level, line-side counter and
// transmit remaining count. Assumes fifo_level never exceeds DEPTH.
module req_decode
    import dma_req_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    parameter int CNT_W = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [CNT_W-1:0] line_cnt,
    input  logic [CNT_W-1:0] tx_remain,
    output req_kind_e        kind
);
    localparam logic [LVL_W-1:0] LVL_BURST = LVL_W'(BURST);
    localparam logic [LVL_W-1:0] LVL_DEPTH = LVL_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_BURST = CNT_W'(BURST);

    logic [LVL_W-1:0] free_slots;
    logic             line_done;
    req_kind_e        rx_kind;
    req_kind_e        tx_kind;

    // Free FIFO entries and the line-side completion flag.
    always_comb begin
        free_slots = LVL_DEPTH - fifo_level;
        line_done  = (line_cnt == '0);
    end

    // Receive choice: drain by bursts while data flows, finish with last requests.
    always_comb begin
        if (fifo_level > LVL_BURST) begin
            rx_kind = REQ_BURST;
        end else if (fifo_level == LVL_BURST) begin
            rx_kind = line_done ? REQ_LBURST : REQ_BURST;
        end else if (!line_done || fifo_level == '0) begin
            rx_kind = REQ_NONE;
        end else if (fifo_level == LVL_W'(1)) begin
            rx_kind = REQ_LSINGLE;
        end else begin
            rx_kind = REQ_SINGLE;
        end
    end

    // Transmit choice: by words left to write, gated by FIFO free space.
    always_comb begin
        tx_kind = REQ_NONE;
        if (tx_remain > CNT_BURST) begin
            if (free_slots >= LVL_BURST) tx_kind = REQ_BURST;
        end else if (tx_remain == CNT_BURST) begin
            if (free_slots >= LVL_BURST) tx_kind = REQ_LBURST;
        end else if (tx_remain == CNT_W'(1)) begin
            if (free_slots != '0) tx_kind = REQ_LSINGLE;
        end else if (tx_remain != '0) begin
            if (free_slots != '0) tx_kind = REQ_SINGLE;
        end
    end

    // Direction select.
    always_comb begin
        kind = dir_tx ? tx_kind : rx_kind;
    end
endmodule

// File: rtl/req_out_reg.sv
// Request output register.
// Turns the selected kind into four mutually exclusive registered lines.
// The DMA clear input forces all lines low for the following cycle.
module req_out_reg
    import dma_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dma_clr,
    input  req_kind_e kind,
    output logic      req_single,
    output logic      req_burst,
    output logic      req_last_single,
    output logic      req_last_burst
);
    // Register one-hot request lines, cleared by reset or by DMA clear.
    always_ff @(posedge clk) begin
        if (!rst_n || dma_clr) begin
            req_single      <= 1'b0;
            req_burst       <= 1'b0;
            req_last_single <= 1'b0;
            req_last_burst  <= 1'b0;
        end else begin
            req_single      <= (kind == REQ_SINGLE);
            req_burst       <= (kind == REQ_BURST);
            req_last_single <= (kind == REQ_LSINGLE);
            req_last_burst  <= (kind == REQ_LBURST);
        end
    end
endmodule

// File: rtl/dma_req_gen.sv
// DMA request generator for a peripheral data FIFO.
// Selects single, burst, last-single or last-burst requests for receive and
// transmit. Never asks for a burst when fewer than BURST words remain.
// Assumes fifo_level <= DEPTH and that line_cnt comes from the line-side engine.
module dma_req_gen
    import dma_req_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [CNT_W-1:0] line_cnt,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             start,
    input  logic             push,
    input  logic             dma_clr,
    output logic             req_single,
    output logic             req_burst,
    output logic             req_last_single,
    output logic             req_last_burst
);
    logic [CNT_W-1:0] tx_rem;
    req_kind_e        next_kind;

    tx_remain_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .push     (push),
        .xfer_len (xfer_len),
        .remain   (tx_rem)
    );

    req_decode #(.DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_dec (
        .dir_tx     (dir_tx),
        .fifo_level (fifo_level),
        .line_cnt   (line_cnt),
        .tx_remain  (tx_rem),
        .kind       (next_kind)
    );

    req_out_reg u_out (
        .clk             (clk),
        .rst_n           (rst_n),
        .dma_clr         (dma_clr),
        .kind            (next_kind),
        .req_single      (req_single),
        .req_burst       (req_burst),
        .req_last_single (req_last_single),
        .req_last_burst  (req_last_burst)
    );
endmodule

// File: rtl/dma_req_gen_chk.sv
// Property checker for dma_req_gen, attached by bind below.
// Assumes fifo_level stays within the FIFO depth.
module dma_req_gen_chk #(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    parameter int CNT_W = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_tx,
    input logic [LVL_W-1:0] fifo_level,
    input logic [CNT_W-1:0] line_cnt,
    input logic [CNT_W-1:0] tx_rem,
    input logic             dma_clr,
    input logic             req_single,
    input logic             req_burst,
    input logic             req_last_single,
    input logic             req_last_burst
);
    logic [3:0] reqs;
    assign reqs = {req_last_burst, req_last_single, req_burst, req_single};

    // R9
    onehot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    // R10
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_clr |=> (reqs == 4'b0000));

    // R2
    rx_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && !dma_clr && fifo_level > LVL_W'(BURST)) |=> req_burst);

    // R5
    rx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && line_cnt != '0 && fifo_level < LVL_W'(BURST)) |=> (reqs == 4'b0000));

    // R7
    tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && fifo_level == LVL_W'(DEPTH)) |=> (reqs == 4'b0000));

    // R8
    tx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && tx_rem == '0) |=> (reqs == 4'b0000));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (reqs == 4'b0000 && tx_rem == '0));
endmodule

bind dma_req_gen dma_req_gen_chk #(
    .DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .dir_tx          (dir_tx),
    .fifo_level      (fifo_level),
    .line_cnt        (line_cnt),
    .tx_rem          (tx_rem),
    .dma_clr         (dma_clr),
    .req_single      (req_single),
    .req_burst       (req_burst),
    .req_last_single (req_last_single),
    .req_last_burst  (req_last_burst)
);

// File: tb/test_dma_req_gen.sv
module test_dma_req_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_tx = 1'b0;
    logic [4:0]  fifo_level = '0;
    logic [15:0] line_cnt = '0;
    logic [15:0] xfer_len = '0;
    logic        start = 1'b0;
    logic        push = 1'b0;
    logic        dma_clr = 1'b0;
    logic        req_single, req_burst, req_last_single, req_last_burst;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_gen i_dma_req_gen (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .fifo_level(fifo_level),
        .line_cnt(line_cnt), .xfer_len(xfer_len), .start(start), .push(push),
        .dma_clr(dma_clr), .req_single(req_single), .req_burst(req_burst),
        .req_last_single(req_last_single), .req_last_burst(req_last_burst)
    );

    // Expected codes {last_burst, last_single, burst, single}
    localparam logic [3:0] NO = 4'b0000, SG = 4'b0001, BU = 4'b0010,
                           LS = 4'b0100, LB = 4'b1000;

    // Vector: {dir_tx, fifo_level, count (line_cnt or xfer_len), expected}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  16'd0,  NO},  // R5 empty
        {1'b0, 5'd1,  16'd0,  LS},  // R3
        {1'b0, 5'd5,  16'd0,  SG},  // R1
        {1'b0, 5'd7,  16'd0,  SG},  // R1 upper edge
        {1'b0, 5'd2,  16'd0,  SG},  // R1 lower edge
        {1'b0, 5'd8,  16'd0,  LB},  // R4
        {1'b0, 5'd8,  16'd3,  BU},  // R2 exactly eight
        {1'b0, 5'd9,  16'd0,  BU},  // R2 above eight
        {1'b0, 5'd16, 16'd5,  BU},  // R2 full
        {1'b0, 5'd5,  16'd4,  NO},  // R5 wait
        {1'b0, 5'd1,  16'd2,  NO},  // R5 wait
        {1'b1, 5'd0,  16'd1,  LS},  // R6
        {1'b1, 5'd16, 16'd1,  NO},  // R7 full
        {1'b1, 5'd15, 16'd4,  SG},  // R7 one free
        {1'b1, 5'd8,  16'd8,  LB},  // R6
        {1'b1, 5'd9,  16'd8,  NO},  // R7 seven free
        {1'b1, 5'd0,  16'd20, BU},  // R6
        {1'b1, 5'd8,  16'd9,  BU},  // R6/R7 eight free
        {1'b1, 5'd9,  16'd9,  NO},  // R7
        {1'b1, 5'd0,  16'd7,  SG},  // R6
        {1'b1, 5'd0,  16'd0,  NO}   // R8 zero length
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {req_last_burst, req_last_single, req_burst, req_single};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b", tag, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset with inputs that would request a burst
        fifo_level = 5'd12;
        step();
        step();
        check(NO, "R11 reset state");
        rst_n = 1'b1;
        step();
        check(BU, "R2 after reset release");

        // Table walk: R1..R8
        for (int i = 0; i < NVEC; i++) begin
            dir_tx     = VEC[i][25];
            fifo_level = VEC[i][24:20];
            if (VEC[i][25]) begin
                line_cnt = '0;
                xfer_len = VEC[i][19:4];
                start    = 1'b1;
                step();
                start    = 1'b0;
            end else begin
                line_cnt = VEC[i][19:4];
            end
            step();
            check(VEC[i][3:0], $sformatf("R1-8 vector %0d", i));
        end

        // R10: clear drops a pending burst for one cycle
        dir_tx = 1'b0; line_cnt = '0; fifo_level = 5'd10;
        step();
        dma_clr = 1'b1;
        step();
        check(NO, "R10 clear cycle");
        dma_clr = 1'b0;
        step();
        check(BU, "R10 resume");

        // R8: load 10, push twice, last burst at 8
        dir_tx = 1'b1; fifo_level = 5'd0; xfer_len = 16'd10; start = 1'b1;
        step();
        start = 1'b0; push = 1'b1;
        step();
        step();
        push = 1'b0;
        step();
        check(LB, "R8 decrement to eight");
        // R9: output follows previous cycle; push once more -> 7, single
        push = 1'b1;
        step();
        push = 1'b0;
        check(LB, "R9 one-cycle latency");
        step();
        check(SG, "R8 decrement to seven");

        // R8: saturate at zero
        xfer_len = 16'd1; start = 1'b1;
        step();
        start = 1'b0; push = 1'b1;
        step();
        step();
        step();
        push = 1'b0;
        step();
        check(NO, "R8 saturate at zero");

        // R11: reset clears the remaining count
        xfer_len = 16'd5; start = 1'b1;
        step();
        start = 1'b0;
        step();
        check(SG, "R6 five remain");
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check(NO, "R11 outputs cleared");
        step();
        check(NO, "R11 count cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule